// File: doc/BRIEF.md
# Time-Multiplexed Second-Order IIR Section

This block computes one second-order recursive filter section. All four additions share a single adder with one pipeline stage, and all four multiplications share a single multiplier with two pipeline stages. One filter iteration takes four clock cycles. A two-bit phase counter sets which operation each unit runs in each cycle. Only two data registers hold the recursive state between iterations. The remaining storage is the pipeline registers of the two units and one output register.

The section uses the canonical (direct form II) structure: `w(n) = x(n) + FBK1·w(n-1) + FBK2·w(n-2)` and `y(n) = w(n) + FWD1·w(n-1) + FWD2·w(n-2)`. The four coefficients are parameters in Q1.15 format. The surrounding logic presents one sample each time `inReady` is high. It collects one result each time `outValid` pulses.

Top module: `folded_biquad`

## Requirements
- R1: While reset is held, `outValid` is 0, `sampleOut` is 0 and `inReady` is 1, which marks phase 0.
- R2: `inReady` is high in exactly one cycle out of every four, with a period of four cycles.
- R3: `sampleIn` is captured only in a cycle where `inReady` is high. Values driven in the other three cycles have no effect on any result.
- R4: `outValid` is a single-cycle pulse. It occurs in the cycle after an `inReady` cycle, and it first occurs after the first complete iteration.
- R5: Each output equals the direct form II result given above. Products use the full 32-bit signed product, arithmetically shifted right by 15, with the low 16 bits kept. Additions wrap modulo 2^16.
- R6: The result for a sample accepted in cycle C is presented with `outValid` in cycle C+5.
- R7: `sampleOut` holds its value in every cycle where `outValid` is low.
- R8: An overflow in any addition or product wraps in two's complement. No saturation is applied.
- R9: The recursive state starts at zero after reset, so the first output equals the first input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | DATA_W | Signed input sample, taken when inReady is high |
| inReady | output | 1 | High in the phase-0 cycle of each iteration |
| sampleOut | output | DATA_W | Signed filtered sample |
| outValid | output | 1 | One-cycle strobe marking a new sampleOut |

## Verification
The assertions check the rhythm of the handshake on every cycle. They cover the four-cycle period of `inReady`, the placement of `outValid` in the cycle after `inReady` as a single-cycle pulse, and `sampleOut` holding between strobes. Whether the shared units are steered correctly can only be shown by the bench's scenarios. That covers bit-exact values against a behavioural model, wrap-around under full-scale inputs, the zero initial state, the five-cycle latency, and immunity to values driven on `sampleIn` outside phase 0.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  localparam int FOLD = 4;
  localparam int PH_W = $clog2(FOLD);

  typedef enum logic [1:0] {
    COEF_FWD1 = 2'd0,
    COEF_FWD2 = 2'd1,
    COEF_FBK2 = 2'd2,
    COEF_FBK1 = 2'd3
  } coef_sel_e;

  typedef struct packed {
    logic      addTakeIn;   // adder operand A from sampleIn instead of adder feedback
    coef_sel_e coefSel;     // coefficient fed to the multiplier
    logic      mulTakeOld;  // multiplier operand from older state register
    logic      stateShift;  // advance the two-entry state
    logic      outCapture;  // load the output register
  } fbq_ctrl_t;
endpackage

// File: rtl/fbq_ctrl.sv
module fbq_ctrl
  import fbq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  output fbq_ctrl_t strobes,
  output logic      inReady,
  output logic      outValid
);
  logic [PH_W-1:0] phase;
  logic            primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= '0;
      primed   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      phase    <= phase + 1'b1;
      if (phase == PH_W'(FOLD - 1)) primed <= 1'b1;
      outValid <= strobes.outCapture;
    end
  end

  // Schedule: adder  ph0 x+FBK2*w2, ph1 +FBK1*w1 -> w, ph2 w+FWD1*w1, ph3 +FWD2*w2 -> y
  //           mult   ph0 FWD1*w1, ph1 FWD2*w2, ph2 FBK2*w1(next), ph3 FBK1*w(new)
  always_comb begin
    strobes = '0;
    unique case (phase)
      2'd0: begin
        strobes.addTakeIn  = 1'b1;
        strobes.coefSel    = COEF_FWD1;
        strobes.outCapture = primed;
      end
      2'd1: begin
        strobes.coefSel    = COEF_FWD2;
        strobes.mulTakeOld = 1'b1;
      end
      2'd2: begin
        strobes.coefSel    = COEF_FBK2;
        strobes.stateShift = 1'b1;
      end
      default: begin
        strobes.coefSel    = COEF_FBK1;
      end
    endcase
  end

  assign inReady = (phase == '0);
endmodule

// File: rtl/fbq_datapath.sv
module fbq_datapath
  import fbq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC   = 15,
  parameter logic signed [DATA_W-1:0] FBK1 = 16'sd16384,
  parameter logic signed [DATA_W-1:0] FBK2 = -16'sd8192,
  parameter logic signed [DATA_W-1:0] FWD1 = 16'sd24576,
  parameter logic signed [DATA_W-1:0] FWD2 = 16'sd8192
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fbq_ctrl_t                strobes,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] addOut, multOut, stateNew, stateOld;
  logic signed [DATA_W-1:0] addA, coefVal, mulOpnd;
  logic signed [PROD_W-1:0] prodReg, coefExt, opndExt;

  always_comb begin
    unique case (strobes.coefSel)
      COEF_FWD1: coefVal = FWD1;
      COEF_FWD2: coefVal = FWD2;
      COEF_FBK2: coefVal = FBK2;
      default:   coefVal = FBK1;
    endcase
  end

  assign addA    = strobes.addTakeIn  ? sampleIn : addOut;
  assign mulOpnd = strobes.mulTakeOld ? stateOld : stateNew;
  assign coefExt = PROD_W'(coefVal);
  assign opndExt = PROD_W'(mulOpnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addOut    <= '0;
      prodReg   <= '0;
      multOut   <= '0;
      stateNew  <= '0;
      stateOld  <= '0;
      sampleOut <= '0;
    end else begin
      addOut  <= addA + multOut;
      prodReg <= coefExt * opndExt;
      multOut <= DATA_W'(prodReg >>> FRAC);
      if (strobes.stateShift) begin
        stateOld <= stateNew;
        stateNew <= addOut;
      end
      if (strobes.outCapture) sampleOut <= addOut;
    end
  end
endmodule

// File: rtl/folded_biquad.sv
module folded_biquad
  import fbq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC   = 15,
  parameter logic signed [DATA_W-1:0] FBK1 = 16'sd16384,
  parameter logic signed [DATA_W-1:0] FBK2 = -16'sd8192,
  parameter logic signed [DATA_W-1:0] FWD1 = 16'sd24576,
  parameter logic signed [DATA_W-1:0] FWD2 = 16'sd8192
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic                     inReady,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     outValid
);
  fbq_ctrl_t strobes;

  fbq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inReady(inReady), .outValid(outValid)
  );

  fbq_datapath #(
    .DATA_W(DATA_W), .FRAC(FRAC),
    .FBK1(FBK1), .FBK2(FBK2), .FWD1(FWD1), .FWD2(FWD2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sampleIn(sampleIn), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/fbq_checker.sv
module fbq_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic [DATA_W-1:0] sampleOut
);
  logic [2:0] cycSinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) cycSinceRst <= '0;
    else if (cycSinceRst != 3'd7) cycSinceRst <= cycSinceRst + 3'd1;
  end

  assert_ready_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycSinceRst >= 3'd4) |-> (inReady == $past(inReady, 4)));

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);

  assert_valid_after_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cycSinceRst >= 3'd1 && outValid) |-> $past(inReady));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cycSinceRst >= 3'd1 && !outValid) |-> $stable(sampleOut));
endmodule

bind folded_biquad fbq_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .inReady(inReady),
  .outValid(outValid), .sampleOut(sampleOut)
);

// File: tb/folded_biquad_tb_top.sv
module folded_biquad_tb_top;
  localparam int NS = 240;
  localparam logic signed [15:0] C_FBK1 = 16'sd16384;
  localparam logic signed [15:0] C_FBK2 = -16'sd8192;
  localparam logic signed [15:0] C_FWD1 = 16'sd24576;
  localparam logic signed [15:0] C_FWD2 = 16'sd8192;

  logic clk = 1'b0;
  logic rstN;
  logic signed [15:0] sampleIn, sampleOut;
  logic inReady, outValid;

  always #4 clk = ~clk;

  folded_biquad #(.FBK1(C_FBK1), .FBK2(C_FBK2), .FWD1(C_FWD1), .FWD2(C_FWD2)) dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn),
    .inReady(inReady), .sampleOut(sampleOut), .outValid(outValid)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic signed [15:0] xs [NS];
  logic signed [15:0] ys [NS];
  int accCyc [NS];

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] qmul(input logic signed [15:0] c, input logic signed [15:0] v);
    logic signed [31:0] a, b, p;
    a = c; b = v; p = a * b;
    return p[30:15];
  endfunction

  task automatic buildModel();
    logic signed [15:0] w1, w2, w, y;
    w1 = 0; w2 = 0;
    for (int i = 0; i < NS; i++) begin
      w  = xs[i] + qmul(C_FBK1, w1) + qmul(C_FBK2, w2);
      y  = w + qmul(C_FWD1, w1) + qmul(C_FWD2, w2);
      ys[i] = y;
      w2 = w1; w1 = w;
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL R6 watchdog: actual no completion expected %0d outputs", NS);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int inCnt, outCnt, lastReadyCyc;
    bit prevReady, haveOut, seenReady;
    logic signed [15:0] lastOut;
    string req;
    void'($urandom(32'd2718));
    // directed: impulse (R9), zeros, full-scale runs for wrap (R8), then random
    xs[0] = 16'sd32767;
    for (int i = 1; i < 12; i++) xs[i] = 16'sd0;
    for (int i = 12; i < 20; i++) xs[i] = 16'sd32767;
    for (int i = 20; i < 28; i++) xs[i] = -16'sd32768;
    for (int i = 28; i < NS; i++) xs[i] = 16'($urandom);
    buildModel();

    rstN = 1'b0; sampleIn = 16'sd1234;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    chk(sampleOut == 16'sd0, "R1 sampleOut in reset", int'(sampleOut), 0);
    chk(inReady == 1'b1, "R1 inReady in reset", int'(inReady), 1);
    rstN = 1'b1;
    inCnt = 0; outCnt = 0; prevReady = 1'b0; haveOut = 1'b0; seenReady = 1'b0;
    lastReadyCyc = 0; lastOut = '0;

    while (outCnt < NS) begin
      if (outValid) begin
        req = (outCnt == 0) ? "R9" : ((outCnt >= 12 && outCnt < 28) ? "R8" : "R5");
        chk(sampleOut == ys[outCnt], {req, " R3 output value"}, int'(sampleOut), int'(ys[outCnt]));
        chk(cyc - accCyc[outCnt] == 5, "R6 latency", cyc - accCyc[outCnt], 5);
        chk(prevReady, "R4 valid follows ready", int'(prevReady), 1);
        lastOut = sampleOut; haveOut = 1'b1;
        outCnt++;
      end else if (haveOut) begin
        chk(sampleOut == lastOut, "R7 output hold", int'(sampleOut), int'(lastOut));
      end
      if (inReady) begin
        if (seenReady) chk(cyc - lastReadyCyc == 4, "R2 ready period", cyc - lastReadyCyc, 4);
        seenReady = 1'b1; lastReadyCyc = cyc;
        if (inCnt < NS) begin
          sampleIn = xs[inCnt]; accCyc[inCnt] = cyc; inCnt++;
        end else sampleIn = 16'($urandom);
      end else begin
        sampleIn = 16'($urandom);  // R3: must be ignored
      end
      prevReady = inReady;
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule